// File: doc/BRIEF.md
# Fixed-Mode Parallel Port with Floppy Control Decode

This block is a three-port, byte-wide parallel interface on a small register bus. Two input ports hand back the live state of two groups of configuration switches. A third, output-only port holds a byte whose bits drive the control lines of a floppy disk controller. A fourth address holds the mode word.

Exactly one mode word is legal. It selects basic I/O for both groups, with the two switch ports as inputs and both halves of the output port as outputs. Any other mode word raises an error flag and leaves the stored configuration as it was.

Every write to the output port is decoded at once. The block emits one-cycle pulses to finish a transfer, abort an operation and reset the controller. It also drives several level outputs: the interrupt enable, the selected drive, the motor line and the precompensation line.

Top module: `fixed_ppi_fdc`

## Requirements
- R1: After reset the mode register and the output-port latch both read 0x00. All pulse outputs, `modeErr`, `fdcIntEn`, `driveSel`, `motorN` and `precompN` are 0.
- R2: A write of 0x92 to address 3 stores the value, which then reads back at address 3, and clears `modeErr` on the next cycle.
- R3: A write of any other value to address 3 sets `modeErr` from the next cycle. The mode register keeps its previous value.
- R4: While `busRdEn` is high, address 0 returns `switchA` and address 1 returns `switchB` in the same cycle, with no register in between. While `busRdEn` is low, `busRdData` is 0x00.
- R5: A write to address 2 stores the byte in the output latch. Address 2 then reads back the last byte written.
- R6: A write to address 2 with bit 0 set makes `finishPulse` high for the single cycle after the write edge.
- R7: A write to address 2 with bit 1 clear makes `abortPulse` high for the single cycle after the write edge.
- R8: `fdcIntEn` follows bit 2 of the output latch as a level.
- R9: Bits 3 and 4 of the latch select drive 0 and drive 1 and are active low. `driveSel` is 0 when bit 3 is low, and drive 0 wins if both bits are low. `driveSel` is 1 when only bit 4 is low, and 0 when neither bit is low.
- R10: `motorN` follows bit 5 and `precompN` follows bit 6 of the latch, as levels with no pulse.
- R11: A write to address 2 with bit 7 set makes `fdcResetPulse` high for the single cycle after the write edge.
- R12: Pulses come only from writes to address 2. Writes to other addresses, reads and idle cycles leave every pulse output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 switch group A, 1 switch group B, 2 output port, 3 mode |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdEn | input | 1 | Read enable |
| busRdData | output | 8 | Read data, combinational |
| switchA | input | 8 | First switch group |
| switchB | input | 8 | Second switch group |
| modeErr | output | 1 | Unsupported mode word was written |
| finishPulse | output | 1 | Terminate-transfer pulse |
| abortPulse | output | 1 | Abort-operation pulse |
| fdcResetPulse | output | 1 | Controller reset pulse |
| fdcIntEn | output | 1 | Floppy interrupt enable level |
| driveSel | output | 1 | Selected drive number |
| motorN | output | 1 | Motor line, active low |
| precompN | output | 1 | Precompensation line, active low |

## Verification
The output port is driven with random bytes, so every mix of the three pulse bits appears. Directed bytes cover each drive-select combination: both selects low, only one low, and neither low. These patterns separate the priority rule from a plain bit copy, and the active-low abort from an active-high one.

Mode writes alternate between the legal word and random illegal ones. This shows that the error flag sets and clears, and that a bad word never replaces the stored one.

Switch reads change the switch inputs right before each read. A value latched earlier, instead of sampled at the read, would therefore show up as a mismatch.

// File: rtl/ppi_fdc_pkg.sv
package ppi_fdc_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;
  localparam int NUM_DRV   = 2;
  localparam int SEL_W     = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1;
  localparam logic [DATA_W-1:0] MODE_WORD = 8'h92;

  // output-port bit positions, decoded by the floppy controller
  localparam int BIT_TC    = 0;
  localparam int BIT_RDY   = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_SEL0  = 3;
  localparam int BIT_MOT   = 5;
  localparam int BIT_PRE   = 6;
  localparam int BIT_RES   = 7;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_SWA  = 2'd0,
    ADDR_SWB  = 2'd1,
    ADDR_OUT  = 2'd2,
    ADDR_MODE = 2'd3
  } ppiAddr_t;

  typedef struct packed {
    logic              wrOut;
    logic              wrModeOk;
    logic              wrModeBad;
    logic [DATA_W-1:0] data;
  } ppiStrobes_t;
endpackage

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_fdc_pkg::*;
(
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output ppiStrobes_t       stb
);
  logic isMode;
  logic isOut;

  always_comb begin
    isOut         = (busAddr == ADDR_OUT);
    isMode        = (busAddr == ADDR_MODE);
    stb.data      = busWrData;
    stb.wrOut     = busWrEn && isOut;
    stb.wrModeOk  = busWrEn && isMode && (busWrData == MODE_WORD);
    stb.wrModeBad = busWrEn && isMode && (busWrData != MODE_WORD);
  end
endmodule

// File: rtl/ppi_datapath.sv
module ppi_datapath
  import ppi_fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ppiStrobes_t       stb,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] switchA,
  input  logic [DATA_W-1:0] switchB,
  output logic [DATA_W-1:0] busRdData,
  output logic              modeErr,
  output logic              finishPulse,
  output logic              abortPulse,
  output logic              fdcResetPulse,
  output logic              fdcIntEn,
  output logic [SEL_W-1:0]  driveSel,
  output logic              motorN,
  output logic              precompN
);
  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] outLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg       <= '0;
      outLatch      <= '0;
      modeErr       <= 1'b0;
      finishPulse   <= 1'b0;
      abortPulse    <= 1'b0;
      fdcResetPulse <= 1'b0;
    end else begin
      if (stb.wrModeOk) begin
        modeReg <= stb.data;
        modeErr <= 1'b0;
      end else if (stb.wrModeBad) begin
        modeErr <= 1'b1;
      end
      if (stb.wrOut) outLatch <= stb.data;
      finishPulse   <= stb.wrOut &&  stb.data[BIT_TC];
      abortPulse    <= stb.wrOut && !stb.data[BIT_RDY];
      fdcResetPulse <= stb.wrOut &&  stb.data[BIT_RES];
    end
  end

  // lowest-numbered active-low select wins; none selected gives 0
  always_comb begin
    driveSel = '0;
    for (int d = NUM_DRV - 1; d >= 0; d--) begin
      if (!outLatch[BIT_SEL0 + d]) driveSel = SEL_W'(d);
    end
  end

  assign fdcIntEn = outLatch[BIT_IE];
  assign motorN   = outLatch[BIT_MOT];
  assign precompN = outLatch[BIT_PRE];

  always_comb begin
    busRdData = '0;
    if (busRdEn) begin
      case (busAddr)
        ADDR_SWA:  busRdData = switchA;
        ADDR_SWB:  busRdData = switchB;
        ADDR_OUT:  busRdData = outLatch;
        default:   busRdData = modeReg;
      endcase
    end
  end
endmodule

// File: rtl/fixed_ppi_fdc.sv
module fixed_ppi_fdc
  import ppi_fdc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] switchA,
  input  logic [DATA_W-1:0] switchB,
  output logic              modeErr,
  output logic              finishPulse,
  output logic              abortPulse,
  output logic              fdcResetPulse,
  output logic              fdcIntEn,
  output logic [SEL_W-1:0]  driveSel,
  output logic              motorN,
  output logic              precompN
);
  ppiStrobes_t stb;

  ppi_ctrl ctrl_i (
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .stb       (stb)
  );

  ppi_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .busRdEn       (busRdEn),
    .busAddr       (busAddr),
    .switchA       (switchA),
    .switchB       (switchB),
    .busRdData     (busRdData),
    .modeErr       (modeErr),
    .finishPulse   (finishPulse),
    .abortPulse    (abortPulse),
    .fdcResetPulse (fdcResetPulse),
    .fdcIntEn      (fdcIntEn),
    .driveSel      (driveSel),
    .motorN        (motorN),
    .precompN      (precompN)
  );
endmodule

// File: rtl/fixed_ppi_fdc_chk.sv
module fixed_ppi_fdc_chk
  import ppi_fdc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [DATA_W-1:0] busWrData,
  input logic              modeErr,
  input logic              finishPulse,
  input logic              abortPulse,
  input logic              fdcResetPulse,
  input logic              fdcIntEn,
  input logic              motorN,
  input logic              precompN
);
  logic outWr;
  assign outWr = busWrEn && (busAddr == ADDR_OUT);

  // R3
  bad_mode_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MODE && busWrData != MODE_WORD) |=> modeErr);

  // R2
  good_mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == ADDR_MODE && busWrData == MODE_WORD) |=> !modeErr);

  // R6
  finish_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(finishPulse) |-> $past(outWr && busWrData[BIT_TC]));

  // R7
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(abortPulse) |-> $past(outWr && !busWrData[BIT_RDY]));

  // R11
  reset_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fdcResetPulse) |-> $past(outWr && busWrData[BIT_RES]));

  // R12
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!outWr) |=> !(finishPulse || abortPulse || fdcResetPulse));

  // R8
  int_en_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWr |=> (fdcIntEn == $past(busWrData[BIT_IE])));

  // R10
  motor_pre_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    outWr |=> (motorN == $past(busWrData[BIT_MOT]) && precompN == $past(busWrData[BIT_PRE])));
endmodule

bind fixed_ppi_fdc fixed_ppi_fdc_chk chk_i (
  .clk           (clk),
  .rstN          (rstN),
  .busAddr       (busAddr),
  .busWrEn       (busWrEn),
  .busWrData     (busWrData),
  .modeErr       (modeErr),
  .finishPulse   (finishPulse),
  .abortPulse    (abortPulse),
  .fdcResetPulse (fdcResetPulse),
  .fdcIntEn      (fdcIntEn),
  .motorN        (motorN),
  .precompN      (precompN)
);

// File: tb/fixed_ppi_fdc_tb_top.sv
module fixed_ppi_fdc_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic       busRdEn = 1'b0;
  logic [7:0] busRdData;
  logic [7:0] switchA = '0;
  logic [7:0] switchB = '0;
  logic       modeErr, finishPulse, abortPulse, fdcResetPulse;
  logic       fdcIntEn, motorN, precompN;
  logic [0:0] driveSel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] expMode = 8'h00;
  logic [7:0] expOut  = 8'h00;
  logic       expErr  = 1'b0;

  always #5 clk = ~clk;

  fixed_ppi_fdc dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .switchA(switchA), .switchB(switchB), .modeErr(modeErr),
    .finishPulse(finishPulse), .abortPulse(abortPulse),
    .fdcResetPulse(fdcResetPulse), .fdcIntEn(fdcIntEn),
    .driveSel(driveSel), .motorN(motorN), .precompN(precompN)
  );

  function automatic logic expDrive(input logic [7:0] v);
    if (!v[3]) return 1'b0;
    if (!v[4]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic checkLevels();
    check("R3 modeErr", {7'd0, modeErr}, {7'd0, expErr});
    check("R8 fdcIntEn", {7'd0, fdcIntEn}, {7'd0, expOut[2]});
    check("R9 driveSel", {7'd0, driveSel}, {7'd0, expDrive(expOut)});
    check("R10 motorN", {7'd0, motorN}, {7'd0, expOut[5]});
    check("R10 precompN", {7'd0, precompN}, {7'd0, expOut[6]});
  endtask

  task automatic checkPulses(input logic f, input logic a, input logic r);
    check("R6 finishPulse", {7'd0, finishPulse}, {7'd0, f});
    check("R7 abortPulse", {7'd0, abortPulse}, {7'd0, a});
    check("R11 fdcResetPulse", {7'd0, fdcResetPulse}, {7'd0, r});
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    logic isOut;
    isOut = (a == 2'd2);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    if (isOut) expOut = d;
    if (a == 2'd3) begin
      if (d == 8'h92) begin expMode = d; expErr = 1'b0; end
      else expErr = 1'b1;
    end
    checkPulses(isOut && d[0], isOut && !d[1], isOut && d[7]);
    checkLevels();
    @(negedge clk);
    // R12: pulse gone after one cycle
    checkPulses(1'b0, 1'b0, 1'b0);
  endtask

  task automatic doRead(input logic [1:0] a, input logic [7:0] exp, input string req);
    busAddr = a; busRdEn = 1'b1;
    #1;
    check(req, busRdData, exp);
    busRdEn = 1'b0;
    #1;
    check("R4 idle read zero", busRdData, 8'h00);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5a17;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pulses", {5'd0, finishPulse, abortPulse, fdcResetPulse}, 8'h00);
    check("R1 levels", {3'd0, modeErr, fdcIntEn, driveSel, motorN, precompN}, 8'h00);
    doRead(2'd2, 8'h00, "R1 output latch");
    doRead(2'd3, 8'h00, "R1 mode reg");

    // R3 bad mode before any good one
    doWrite(2'd3, 8'h80);
    doRead(2'd3, 8'h00, "R3 mode unchanged");
    // R2 good mode
    doWrite(2'd3, 8'h92);
    doRead(2'd3, 8'h92, "R2 mode readback");
    doWrite(2'd3, 8'h9B);
    doRead(2'd3, 8'h92, "R3 mode kept");

    // R9 drive-select corners
    doWrite(2'd2, 8'b0000_0010);  // both low -> drive 0
    doWrite(2'd2, 8'b0000_1010);  // only sel1 low -> drive 1
    doWrite(2'd2, 8'b0001_0010);  // only sel0 low -> drive 0
    doWrite(2'd2, 8'b0001_1010);  // none -> 0
    // R6 R7 R11 all pulses together
    doWrite(2'd2, 8'h81);
    doRead(2'd2, 8'h81, "R5 readback");
    doWrite(2'd2, 8'hFF);
    // R12 writes to switch addresses give no pulses
    doWrite(2'd0, 8'h81);
    doWrite(2'd1, 8'h01);
    doRead(2'd2, 8'hFF, "R5 latch kept");

    for (int i = 0; i < 300; i++) begin
      int op;
      logic [7:0] v;
      op = $urandom_range(0, 5);
      v = 8'($urandom);
      case (op)
        0, 1: doWrite(2'd2, v);
        2: doWrite(2'd3, ($urandom_range(0, 1) == 0) ? 8'h92 : v);
        3: begin switchA = v; doRead(2'd0, v, "R4 switchA"); end
        4: begin switchB = v; doRead(2'd1, v, "R4 switchB"); end
        default: begin
          doRead(2'd2, expOut, "R5 random readback");
          doRead(2'd3, expMode, "R2 random mode readback");
        end
      endcase
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule